// File: doc/BRIEF.md
# Constant-Delay Time-Slot Interchanger

This block switches byte-wide TDM channels between a set of serial input streams and a set of serial output streams. Each stream carries one bit per clock, most significant bit first, with `CHANS` channels of `BITS` bits per frame. At the end of every input channel, the byte collected from each stream is written into a data memory slot addressed by the frame buffer, the stream number and the channel number.

A connection table holds one entry per output stream and output channel. Each entry gives a source stream, a source channel and an enable flag. The entry for the next output channel is fetched one channel early. The data memory holds three frame buffers in rotation, so bytes written in frame N are always read out in frame N+2. Every connection therefore has the same delay, two frames plus the output-minus-input channel offset, whatever the channel pairing.

A frame pulse aligns the channel and bit counters. Between pulses the counters wrap by themselves. The connection table is loaded through a simple synchronous write port.

Top module: `tsi_switch`

## Requirements
- R1: While `rst_ni` is low, every bit of `sout_o` and `oe_o` is 0.
- R2: A byte entering input channel m of frame N appears on an output connected to it with m = n exactly 2 frames later, i.e. 2*CHANS*BITS clock cycles after it entered.
- R3: When the output channel n is greater than the source channel m, the delay is 2*CHANS*BITS + (n-m)*BITS cycles, which is longer than 2 frames.
- R4: When n is less than m, the delay is 2*CHANS*BITS - (m-n)*BITS cycles, which is shorter than 2 frames.
- R5: Any input stream may feed any output stream, and one source channel may feed several output channels and streams in the same frame.
- R6: A connection entry with its enable flag at 0 holds `oe_o` and `sout_o` of that stream at 0 for the whole output channel. An entry with the flag at 1 holds `oe_o` at 1 for the whole channel.
- R7: Bit order is most significant bit first. Bit BITS-1 of a channel byte is carried in the first bit cycle of the channel, on input and on output.
- R8: `fp_i` is driven high during the last bit cycle of a frame, and the next cycle is channel 0, bit 0 of a new frame. Without pulses the counters wrap after CHANS*BITS cycles and switching goes on unchanged.
- R9: An entry written through the connection port during frame k governs its output channel in every frame from k+1 on, until it is rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, one serial bit per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fp_i | input | 1 | Frame pulse, high in the last bit cycle of a frame |
| sin_i | input | STREAMS | Serial input streams |
| sout_o | output | STREAMS | Serial output streams |
| oe_o | output | STREAMS | Per-stream output valid for the current channel |
| cm_we_i | input | 1 | Connection entry write strobe |
| cm_ostream_i | input | $clog2(STREAMS) | Output stream of the entry written |
| cm_ochan_i | input | $clog2(CHANS) | Output channel of the entry written |
| cm_en_i | input | 1 | Enable flag of the entry written |
| cm_src_stream_i | input | $clog2(STREAMS) | Source stream of the entry written |
| cm_src_chan_i | input | $clog2(CHANS) | Source channel of the entry written |

## Verification
At the last bit cycle of every channel, two memory operations happen on the same clock edge. The byte just completed on each input is written, and the source bytes for the next output channel are read. At a frame boundary, the write for the final input channel and the read for output channel 0 land on that same edge in different frame buffers. The bench drives fresh random bytes on every input channel of every frame, so any buffer overlap or off-by-one rotation shows up as a wrong bit. Each output bit is compared against a model that fetches the byte from two frames earlier.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int unsigned NUM_FBUF = 3;
  typedef logic [1:0] fbuf_t;

  function automatic fbuf_t fbuf_next(input fbuf_t b);
    return (b == 2'd2) ? 2'd0 : b + 2'd1;
  endfunction
endpackage

// File: rtl/tsi_timing.sv
module tsi_timing
  import tsi_pkg::*;
#(
  parameter int unsigned CHANS = 8,
  parameter int unsigned BITS  = 8,
  localparam int unsigned CW = $clog2(CHANS),
  localparam int unsigned BW = $clog2(BITS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fp_i,
  output logic [BW-1:0] bit_o,
  output logic [CW-1:0] chan_o,
  output logic [CW-1:0] nxt_chan_o,
  output fbuf_t         wr_buf_o,
  output fbuf_t         rd_buf_o,
  output logic          last_bit_o,
  output logic          load_o,
  output logic          frame_evt_o
);
  logic last_chan;

  assign last_bit_o  = bit_o == BW'(BITS - 1);
  assign last_chan   = chan_o == CW'(CHANS - 1);
  assign frame_evt_o = fp_i | (last_bit_o & last_chan);
  assign load_o      = fp_i | last_bit_o;
  assign nxt_chan_o  = frame_evt_o ? '0 : chan_o + 1'b1;
  // buffer read for the channel about to start: two frames behind its writer
  assign rd_buf_o    = frame_evt_o ? fbuf_next(fbuf_next(wr_buf_o)) : fbuf_next(wr_buf_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_o    <= BW'(BITS - 1);
      chan_o   <= CW'(CHANS - 1);
      wr_buf_o <= '0;
    end else if (load_o) begin
      bit_o  <= '0;
      chan_o <= nxt_chan_o;
      if (frame_evt_o) wr_buf_o <= fbuf_next(wr_buf_o);
    end else begin
      bit_o <= bit_o + 1'b1;
    end
  end
endmodule

// File: rtl/tsi_deser.sv
module tsi_deser #(
  parameter int unsigned STREAMS = 4,
  parameter int unsigned BITS    = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [STREAMS-1:0]             sin_i,
  output logic [STREAMS-1:0][BITS-1:0]   word_o
);
  logic [STREAMS-1:0][BITS-1:0] sh_q;

  for (genvar s = 0; s < STREAMS; s++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q[s] <= '0;
      else         sh_q[s] <= {sh_q[s][BITS-2:0], sin_i[s]};
    end
    // completed byte visible during the last bit cycle
    assign word_o[s] = {sh_q[s][BITS-2:0], sin_i[s]};
  end
endmodule

// File: rtl/tsi_dmem.sv
module tsi_dmem
  import tsi_pkg::*;
#(
  parameter int unsigned STREAMS = 4,
  parameter int unsigned CHANS   = 8,
  parameter int unsigned BITS    = 8,
  localparam int unsigned SW    = $clog2(STREAMS),
  localparam int unsigned CW    = $clog2(CHANS),
  localparam int unsigned DEPTH = NUM_FBUF * STREAMS * CHANS,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic                         clk_i,
  input  logic                         we_i,
  input  fbuf_t                        wr_buf_i,
  input  logic [CW-1:0]                wr_chan_i,
  input  logic [STREAMS-1:0][BITS-1:0] wdata_i,
  input  fbuf_t                        rd_buf_i,
  input  logic [STREAMS-1:0][SW-1:0]   rd_stream_i,
  input  logic [STREAMS-1:0][CW-1:0]   rd_chan_i,
  output logic [STREAMS-1:0][BITS-1:0] rdata_o
);
  logic [BITS-1:0] mem [DEPTH];

  function automatic logic [AW-1:0] slot(input fbuf_t b, input int unsigned s, input int unsigned c);
    return AW'((int'(b) * STREAMS + s) * CHANS + c);
  endfunction

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      for (int s = 0; s < STREAMS; s++) mem[slot(wr_buf_i, s, wr_chan_i)] <= wdata_i[s];
    end
  end

  for (genvar s = 0; s < STREAMS; s++) begin : g_rd
    assign rdata_o[s] = mem[slot(rd_buf_i, rd_stream_i[s], rd_chan_i[s])];
  end
endmodule

// File: rtl/tsi_cmem.sv
module tsi_cmem #(
  parameter int unsigned STREAMS = 4,
  parameter int unsigned CHANS   = 8,
  localparam int unsigned SW = $clog2(STREAMS),
  localparam int unsigned CW = $clog2(CHANS),
  localparam int unsigned N  = STREAMS * CHANS
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [SW-1:0]              wr_ostream_i,
  input  logic [CW-1:0]              wr_ochan_i,
  input  logic                       wr_en_i,
  input  logic [SW-1:0]              wr_sstream_i,
  input  logic [CW-1:0]              wr_schan_i,
  input  logic                       load_i,
  input  logic [CW-1:0]              nxt_chan_i,
  output logic [STREAMS-1:0]         q_en_o,
  output logic [STREAMS-1:0][SW-1:0] q_sstream_o,
  output logic [STREAMS-1:0][CW-1:0] q_schan_o
);
  logic [N-1:0]         en_m;
  logic [SW-1:0]        ss_m [N];
  logic [CW-1:0]        sc_m [N];
  logic [CW-1:0]        pre_chan;

  // fetch one channel beyond the one being loaded now
  assign pre_chan = (nxt_chan_i == CW'(CHANS - 1)) ? '0 : nxt_chan_i + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_m <= '0;
      for (int i = 0; i < N; i++) begin
        ss_m[i] <= '0;
        sc_m[i] <= '0;
      end
    end else if (we_i) begin
      en_m[int'(wr_ostream_i) * CHANS + int'(wr_ochan_i)] <= wr_en_i;
      ss_m[int'(wr_ostream_i) * CHANS + int'(wr_ochan_i)] <= wr_sstream_i;
      sc_m[int'(wr_ostream_i) * CHANS + int'(wr_ochan_i)] <= wr_schan_i;
    end
  end

  for (genvar s = 0; s < STREAMS; s++) begin : g_pf
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q_en_o[s]      <= 1'b0;
        q_sstream_o[s] <= '0;
        q_schan_o[s]   <= '0;
      end else if (load_i) begin
        q_en_o[s]      <= en_m[s * CHANS + int'(pre_chan)];
        q_sstream_o[s] <= ss_m[s * CHANS + int'(pre_chan)];
        q_schan_o[s]   <= sc_m[s * CHANS + int'(pre_chan)];
      end
    end
  end
endmodule

// File: rtl/tsi_ser.sv
module tsi_ser #(
  parameter int unsigned STREAMS = 4,
  parameter int unsigned BITS    = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         load_i,
  input  logic [STREAMS-1:0]           en_i,
  input  logic [STREAMS-1:0][BITS-1:0] rdata_i,
  output logic [STREAMS-1:0]           sout_o,
  output logic [STREAMS-1:0]           oe_o
);
  logic [STREAMS-1:0][BITS-1:0] sh_q;

  for (genvar s = 0; s < STREAMS; s++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_q[s] <= '0;
        oe_o[s] <= 1'b0;
      end else if (load_i) begin
        sh_q[s] <= en_i[s] ? rdata_i[s] : '0;
        oe_o[s] <= en_i[s];
      end else begin
        sh_q[s] <= {sh_q[s][BITS-2:0], 1'b0};
      end
    end
    assign sout_o[s] = sh_q[s][BITS-1];
  end
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
#(
  parameter int unsigned STREAMS = 4,
  parameter int unsigned CHANS   = 8,
  parameter int unsigned BITS    = 8,
  localparam int unsigned SW = $clog2(STREAMS),
  localparam int unsigned CW = $clog2(CHANS),
  localparam int unsigned BW = $clog2(BITS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fp_i,
  input  logic [STREAMS-1:0] sin_i,
  output logic [STREAMS-1:0] sout_o,
  output logic [STREAMS-1:0] oe_o,
  input  logic               cm_we_i,
  input  logic [SW-1:0]      cm_ostream_i,
  input  logic [CW-1:0]      cm_ochan_i,
  input  logic               cm_en_i,
  input  logic [SW-1:0]      cm_src_stream_i,
  input  logic [CW-1:0]      cm_src_chan_i
);
  logic [BW-1:0]                bit_w;
  logic [CW-1:0]                chan_w, nxt_chan_w;
  fbuf_t                        wr_buf_w, rd_buf_w;
  logic                         last_bit_w, load_w, frame_evt_w;
  logic [STREAMS-1:0][BITS-1:0] in_word_w, rd_word_w;
  logic [STREAMS-1:0]           q_en_w;
  logic [STREAMS-1:0][SW-1:0]   q_ss_w;
  logic [STREAMS-1:0][CW-1:0]   q_sc_w;

  tsi_timing #(.CHANS(CHANS), .BITS(BITS)) u_timing (
    .clk_i, .rst_ni, .fp_i,
    .bit_o(bit_w), .chan_o(chan_w), .nxt_chan_o(nxt_chan_w),
    .wr_buf_o(wr_buf_w), .rd_buf_o(rd_buf_w),
    .last_bit_o(last_bit_w), .load_o(load_w), .frame_evt_o(frame_evt_w)
  );

  tsi_deser #(.STREAMS(STREAMS), .BITS(BITS)) u_deser (
    .clk_i, .rst_ni, .sin_i, .word_o(in_word_w)
  );

  tsi_dmem #(.STREAMS(STREAMS), .CHANS(CHANS), .BITS(BITS)) u_dmem (
    .clk_i,
    .we_i(last_bit_w), .wr_buf_i(wr_buf_w), .wr_chan_i(chan_w), .wdata_i(in_word_w),
    .rd_buf_i(rd_buf_w), .rd_stream_i(q_ss_w), .rd_chan_i(q_sc_w), .rdata_o(rd_word_w)
  );

  tsi_cmem #(.STREAMS(STREAMS), .CHANS(CHANS)) u_cmem (
    .clk_i, .rst_ni,
    .we_i(cm_we_i), .wr_ostream_i(cm_ostream_i), .wr_ochan_i(cm_ochan_i),
    .wr_en_i(cm_en_i), .wr_sstream_i(cm_src_stream_i), .wr_schan_i(cm_src_chan_i),
    .load_i(load_w), .nxt_chan_i(nxt_chan_w),
    .q_en_o(q_en_w), .q_sstream_o(q_ss_w), .q_schan_o(q_sc_w)
  );

  tsi_ser #(.STREAMS(STREAMS), .BITS(BITS)) u_ser (
    .clk_i, .rst_ni, .load_i(load_w), .en_i(q_en_w), .rdata_i(rd_word_w),
    .sout_o, .oe_o
  );
endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk
  import tsi_pkg::*;
#(
  parameter int unsigned STREAMS = 4,
  parameter int unsigned CHANS   = 8,
  parameter int unsigned BITS    = 8,
  localparam int unsigned CW = $clog2(CHANS),
  localparam int unsigned BW = $clog2(BITS)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               fp_i,
  input logic [BW-1:0]      bit_i,
  input logic [CW-1:0]      chan_i,
  input fbuf_t              wr_buf_i,
  input fbuf_t              rd_buf_i,
  input logic               load_i,
  input logic               frame_evt_i,
  input logic [STREAMS-1:0] sout_i,
  input logic [STREAMS-1:0] oe_i
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_quiet_r1: assert (sout_i == '0 && oe_i == '0);
    end
  end

  p_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_i == BW'(BITS - 1) && chan_i == CW'(CHANS - 1)) |=> (bit_i == '0 && chan_i == '0));

  p_fp_align_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp_i |=> (bit_i == '0 && chan_i == '0));

  p_buf_rotate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_evt_i |=> wr_buf_i == fbuf_next($past(wr_buf_i)));

  p_rd_apart_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (rd_buf_i != wr_buf_i && rd_buf_i < 2'd3));

  p_dark_when_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sout_i & ~oe_i) == '0);

  p_oe_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_i != '0) |-> $stable(oe_i));
endmodule

bind tsi_switch tsi_switch_chk #(.STREAMS(STREAMS), .CHANS(CHANS), .BITS(BITS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fp_i(fp_i),
  .bit_i(bit_w), .chan_i(chan_w), .wr_buf_i(wr_buf_w), .rd_buf_i(rd_buf_w),
  .load_i(load_w), .frame_evt_i(frame_evt_w),
  .sout_i(sout_o), .oe_i(oe_o)
);

// File: tb/sim_tsi_switch.sv
module sim_tsi_switch;
  localparam int S  = 4;
  localparam int C  = 8;
  localparam int B  = 8;
  localparam int F  = C * B;
  localparam int SW = $clog2(S);
  localparam int CW = $clog2(C);
  localparam time CLK_PERIOD = 10ns;

  logic clk_i = 1'b0;
  logic rst_ni, fp_i, cm_we_i, cm_en_i;
  logic [S-1:0]  sin_i, sout_o, oe_o;
  logic [SW-1:0] cm_ostream_i, cm_src_stream_i;
  logic [CW-1:0] cm_ochan_i, cm_src_chan_i;

  tsi_switch #(.STREAMS(S), .CHANS(C), .BITS(B)) u0 (.*);

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [B-1:0] in_hist [3][S][C];
  int m_en [S][C], m_ss [S][C], m_sc [S][C];
  int n_en [S][C], n_ss [S][C], n_sc [S][C];

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // kind 0: identity, 1: cross/offset with gaps, 2: random with broadcast
  task automatic build_map(input int kind);
    for (int s = 0; s < S; s++)
      for (int c = 0; c < C; c++) begin
        case (kind)
          0: begin n_en[s][c] = 1; n_ss[s][c] = s; n_sc[s][c] = c; end
          1: begin
            n_en[s][c] = ((s + c) % 5 != 0) ? 1 : 0;
            n_ss[s][c] = s ^ 1; n_sc[s][c] = (c + 3) % C;
          end
          default: begin
            n_en[s][c] = ($urandom % 4 != 0) ? 1 : 0;
            n_ss[s][c] = $urandom % S; n_sc[s][c] = $urandom % C;
            if (c == 0) begin n_en[s][c] = 1; n_ss[s][c] = 2; n_sc[s][c] = 5; end
          end
        endcase
      end
  endtask

  function automatic string tag_for(int s, int n, int b, bit fr, bit first);
    if (m_en[s][n] == 0)  return "R6";
    if (fr)               return "R8";
    if (first)            return "R9";
    if (m_ss[s][n] != s)  return "R5";
    if (b == 0)           return "R7";
    if (n > m_sc[s][n])   return "R3";
    if (n < m_sc[s][n])   return "R4";
    return "R2";
  endfunction

  task automatic run_frame(input int k, input bit use_fp, input bit cfg, input bit chk,
                           input bit fr, input bit first);
    int n, b, exp_v;
    for (int p = 0; p < F; p++) begin
      @(negedge clk_i);
      n = p / B;
      b = p % B;
      if (chk) begin
        for (int s = 0; s < S; s++) begin
          if (m_en[s][n] != 0)
            exp_v = 2 + int'(in_hist[(k + 1) % 3][m_ss[s][n]][m_sc[s][n]][B-1-b]);
          else
            exp_v = 0;
          check(tag_for(s, n, b, fr, first), int'({oe_o[s], sout_o[s]}), exp_v,
                $sformatf("frame %0d stream %0d chan %0d bit %0d {oe,sout}", k, s, n, b));
        end
      end
      if (b == 0)
        for (int s = 0; s < S; s++) in_hist[k % 3][s][n] = B'($urandom);
      for (int s = 0; s < S; s++) sin_i[s] = in_hist[k % 3][s][n][B-1-b];
      fp_i = use_fp && (p == F - 1);
      if (cfg && p < S * C) begin
        cm_we_i         = 1'b1;
        cm_ostream_i    = SW'(p / C);
        cm_ochan_i      = CW'(p % C);
        cm_en_i         = n_en[p / C][p % C] != 0;
        cm_src_stream_i = SW'(n_ss[p / C][p % C]);
        cm_src_chan_i   = CW'(n_sc[p / C][p % C]);
      end else begin
        cm_we_i = 1'b0;
      end
    end
    if (cfg) begin
      m_en = n_en;
      m_ss = n_ss;
      m_sc = n_sc;
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_ni = 1'b0; fp_i = 1'b0; sin_i = '1; cm_we_i = 1'b0; cm_en_i = 1'b0;
    cm_ostream_i = '0; cm_ochan_i = '0; cm_src_stream_i = '0; cm_src_chan_i = '0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      check("R1", int'({oe_o, sout_o}), 0, "outputs during reset");
    end
    rst_ni = 1'b1;
    fp_i   = 1'b1;
    build_map(0);
    run_frame(0, 1, 1, 0, 0, 0);
    run_frame(1, 1, 0, 0, 0, 0);
    run_frame(2, 1, 0, 1, 0, 0);
    run_frame(3, 1, 0, 1, 0, 0);
    build_map(1);
    run_frame(4, 1, 1, 0, 0, 0);
    run_frame(5, 1, 0, 1, 0, 1);
    run_frame(6, 1, 0, 1, 0, 0);
    run_frame(7, 1, 0, 1, 0, 0);
    build_map(2);
    run_frame(8, 1, 1, 0, 0, 0);
    run_frame(9, 1, 0, 1, 0, 1);
    run_frame(10, 0, 0, 1, 0, 0);
    run_frame(11, 0, 0, 1, 1, 0);
    run_frame(12, 1, 0, 1, 1, 0);
    run_frame(13, 1, 0, 1, 0, 0);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule